// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register and arithmetic part of a processor in which every transfer between registers crosses one shared internal bus. It holds eight 32-bit general registers, a program counter, an instruction register, a scratch register, an ALU operand register (Y), an ALU result register (Z) and the two memory-side registers: an address register and a data register. It makes no decisions of its own. On every clock a control word from an external sequencer says which single register drives the bus, which registers capture it, which ALU function to compute, and whether the ALU's first operand is Y or the constant 4.

The ALU has no storage. Its first operand comes from the operand mux and its second straight from the bus. Its result is kept only if Z is loaded. The memory data register has four independent enables. It can load from the bus or from the memory read data, and it can drive the internal bus or the memory write data. A typical register add R3 = R1 + R2 takes three steps: R1 to Y, then R2 on the bus with Add and Z load, then Z to R3.

Top module: `sbus_datapath`

## Requirements
- R1: After the active-low asynchronous reset, every register (general, PC, IR, TEMP, Y, Z, MAR, MDR) holds zero.
- R2: In a cycle, the bus carries the value of the register whose out-enable is set. With no out-enable set, the bus is zero.
- R3: A register whose in-enable is set captures the bus value at the rising clock edge. A register whose in-enable is clear keeps its value. `ir_o` always shows IR.
- R4: Z loads the ALU result when `z_in_i` is set. The ALU codes are: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 pass bus, 6 pass operand mux, 7 zero. Operand A is the mux output and operand B is the bus.
- R5: With `sel_const_i` set, operand A is the constant 4. Otherwise it is Y.
- R6: Subtract computes A + ~B + `carry_i`. Every other ALU code ignores `carry_i`.
- R7: `mem_addr_o` shows MAR. `mem_rd_o` and `mem_wr_o` follow `mem_rd_i` and `mem_wr_i` in the same cycle.
- R8: MDR loads `mem_rdata_i` when `mdr_mem_in_i` and `mem_done_i` are both set. This takes priority over a bus load through `mdr_in_i`. Without `mem_done_i`, the memory load has no effect.
- R9: `mem_wdata_o` always shows MDR. `mem_wdata_en_o` equals `mdr_mem_out_i`.
- R10: At most one out-enable may be set in a cycle. Contention is flagged by an assertion.
- R11: A register may drive the bus and be loaded in the same cycle. The bus then carries the old value, and the new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpr_out_i | input | 8 | Per general register: drive bus |
| gpr_in_i | input | 8 | Per general register: load from bus |
| pc_out_i | input | 1 | PC drives bus |
| pc_in_i | input | 1 | PC loads bus |
| ir_out_i | input | 1 | IR drives bus |
| ir_in_i | input | 1 | IR loads bus |
| tmp_out_i | input | 1 | TEMP drives bus |
| tmp_in_i | input | 1 | TEMP loads bus |
| y_in_i | input | 1 | Y loads bus |
| z_out_i | input | 1 | Z drives bus |
| z_in_i | input | 1 | Z loads ALU result |
| mar_in_i | input | 1 | MAR loads bus |
| mdr_out_i | input | 1 | MDR drives internal bus |
| mdr_in_i | input | 1 | MDR loads internal bus |
| mdr_mem_in_i | input | 1 | MDR loads memory read data (needs mem_done_i) |
| mdr_mem_out_i | input | 1 | MDR drives memory write data |
| sel_const_i | input | 1 | Operand A is constant 4 instead of Y |
| alu_op_i | input | 3 | ALU function code |
| carry_i | input | 1 | Carry-in for subtract |
| mem_rd_i | input | 1 | Read strobe request |
| mem_wr_i | input | 1 | Write strobe request |
| mem_done_i | input | 1 | Memory completion |
| mem_rdata_i | input | 32 | Memory read data |
| mem_addr_o | output | 32 | Memory address (MAR) |
| mem_wdata_o | output | 32 | Memory write data (MDR) |
| mem_wdata_en_o | output | 1 | Write data valid |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| ir_o | output | 32 | Instruction register to decoder |
| bus_o | output | 32 | Internal bus value |

## Verification
Some functions of this block can fall in the same cycle. Two pairs are exercised on purpose. In the first, one register drives the bus while it is also loaded: Z is driven out while Z captures a fresh result, and MDR drives the bus while it loads from memory. In the second, MDR sees a bus load and a memory load together. Each pair is provoked by one control word. A behavioural model of the registers in the bench judges it. The model predicts the old value on the bus in that cycle and the new value in the next, and it resolves the MDR source by the completion input.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [2:0] {
    ALU_ADD      = 3'd0,
    ALU_SUB      = 3'd1,
    ALU_AND      = 3'd2,
    ALU_OR       = 3'd3,
    ALU_XOR      = 3'd4,
    ALU_PASS_BUS = 3'd5,
    ALU_PASS_MUX = 3'd6,
    ALU_ZERO     = 3'd7
  } alu_op_e;
endpackage

// File: rtl/sbus_reg.sv
module sbus_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == $past(d_i));
endmodule

// File: rtl/sbus_bus_mux.sv
module sbus_bus_mux #(
  parameter int DW   = 32,
  parameter int NDRV = 13
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NDRV-1:0]           en_i,
  input  logic [NDRV-1:0][DW-1:0]   data_i,
  output logic [DW-1:0]             bus_o
);
  // AND-OR selection; the single-driver rule is a precondition (R10)
  always_comb begin
    bus_o = '0;
    for (int i = 0; i < NDRV; i++)
      bus_o = bus_o | (data_i[i] & {DW{en_i[i]}});
  end

  a_r10_one_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_i));
  a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (bus_o == '0));
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD:      res_o = a_i + b_i;
      ALU_SUB:      res_o = a_i + ~b_i + {{(DW-1){1'b0}}, cin_i};
      ALU_AND:      res_o = a_i & b_i;
      ALU_OR:       res_o = a_i | b_i;
      ALU_XOR:      res_o = a_i ^ b_i;
      ALU_PASS_BUS: res_o = b_i;
      ALU_PASS_MUX: res_o = a_i;
      default:      res_o = '0;
    endcase
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NREG    = 8,
  parameter int INC_VAL = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] gpr_out_i,
  input  logic [NREG-1:0] gpr_in_i,
  input  logic            pc_out_i,
  input  logic            pc_in_i,
  input  logic            ir_out_i,
  input  logic            ir_in_i,
  input  logic            tmp_out_i,
  input  logic            tmp_in_i,
  input  logic            y_in_i,
  input  logic            z_out_i,
  input  logic            z_in_i,
  input  logic            mar_in_i,
  input  logic            mdr_out_i,
  input  logic            mdr_in_i,
  input  logic            mdr_mem_in_i,
  input  logic            mdr_mem_out_i,
  input  logic            sel_const_i,
  input  logic [2:0]      alu_op_i,
  input  logic            carry_i,
  input  logic            mem_rd_i,
  input  logic            mem_wr_i,
  input  logic            mem_done_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [DW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic            mem_wdata_en_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [DW-1:0]   ir_o,
  output logic [DW-1:0]   bus_o
);
  localparam int IDX_PC  = NREG;
  localparam int IDX_IR  = NREG + 1;
  localparam int IDX_TMP = NREG + 2;
  localparam int IDX_Z   = NREG + 3;
  localparam int IDX_MDR = NREG + 4;
  localparam int NDRV    = NREG + 5;
  localparam logic [DW-1:0] CONST_INC = DW'(INC_VAL);

  logic [NDRV-1:0]         drv_en;
  logic [NDRV-1:0][DW-1:0] drv_data;
  logic [DW-1:0]           bus;
  logic [DW-1:0]           pc_q, ir_q, tmp_q, y_q, z_q, mar_q, mdr_q;
  logic [DW-1:0]           opa, alu_res;

  assign drv_en = {mdr_out_i, z_out_i, tmp_out_i, ir_out_i, pc_out_i, gpr_out_i};

  for (genvar g = 0; g < NREG; g++) begin : g_gpr
    logic [DW-1:0] q;
    sbus_reg #(.DW(DW)) u_gpr (
      .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(gpr_in_i[g]), .d_i(bus), .q_o(q));
    assign drv_data[g] = q;
  end

  sbus_reg #(.DW(DW)) u_pc  (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(pc_in_i),  .d_i(bus),     .q_o(pc_q));
  sbus_reg #(.DW(DW)) u_ir  (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ir_in_i),  .d_i(bus),     .q_o(ir_q));
  sbus_reg #(.DW(DW)) u_tmp (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(tmp_in_i), .d_i(bus),     .q_o(tmp_q));
  sbus_reg #(.DW(DW)) u_y   (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(y_in_i),   .d_i(bus),     .q_o(y_q));
  sbus_reg #(.DW(DW)) u_z   (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(z_in_i),   .d_i(alu_res), .q_o(z_q));
  sbus_reg #(.DW(DW)) u_mar (.clk_i(clk_i), .rst_ni(rst_ni), .ld_i(mar_in_i), .d_i(bus),     .q_o(mar_q));

  assign drv_data[IDX_PC]  = pc_q;
  assign drv_data[IDX_IR]  = ir_q;
  assign drv_data[IDX_TMP] = tmp_q;
  assign drv_data[IDX_Z]   = z_q;
  assign drv_data[IDX_MDR] = mdr_q;

  // memory-side load wins over bus-side load, but only on completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         mdr_q <= '0;
    else if (mdr_mem_in_i && mem_done_i) mdr_q <= mem_rdata_i;
    else if (mdr_in_i)                   mdr_q <= bus;
  end

  sbus_bus_mux #(.DW(DW), .NDRV(NDRV)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(drv_en), .data_i(drv_data), .bus_o(bus));

  assign opa = sel_const_i ? CONST_INC : y_q;

  sbus_alu #(.DW(DW)) u_alu (
    .op_i(alu_op_e'(alu_op_i)), .a_i(opa), .b_i(bus), .cin_i(carry_i), .res_o(alu_res));

  assign mem_addr_o     = mar_q;
  assign mem_wdata_o    = mdr_q;
  assign mem_wdata_en_o = mdr_mem_out_i;
  assign mem_rd_o       = mem_rd_i;
  assign mem_wr_o       = mem_wr_i;
  assign ir_o           = ir_q;
  assign bus_o          = bus;

  a_r8_mem_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdr_mem_in_i && mem_done_i) |=> mdr_q == $past(mem_rdata_i));
  a_r8_no_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mdr_in_i && !(mdr_mem_in_i && mem_done_i)) |=> $stable(mdr_q));
  a_r7_mar_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mar_in_i |=> mem_addr_o == $past(bus_o));
  a_r5_inc_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (z_in_i && sel_const_i && alu_op_i == 3'd0) |=> z_q == $past(bus_o) + CONST_INC);
endmodule

// File: tb/sim_sbus_datapath.sv
module sim_sbus_datapath;
  localparam int DW = 32;
  localparam int NREG = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NREG-1:0] gpr_out, gpr_in;
  logic pc_out, pc_in, ir_out, ir_in, tmp_out, tmp_in, y_in, z_out, z_in, mar_in;
  logic mdr_out, mdr_in, mdr_mem_in, mdr_mem_out, sel_const, carry, mem_rd, mem_wr, mem_done;
  logic [2:0] alu_op;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] mem_addr, mem_wdata, ir_v, bus_v;
  logic mem_wdata_en, mem_rd_v, mem_wr_v;

  sbus_datapath u0 (
    .clk_i(clk), .rst_ni(rst_n), .gpr_out_i(gpr_out), .gpr_in_i(gpr_in),
    .pc_out_i(pc_out), .pc_in_i(pc_in), .ir_out_i(ir_out), .ir_in_i(ir_in),
    .tmp_out_i(tmp_out), .tmp_in_i(tmp_in), .y_in_i(y_in), .z_out_i(z_out), .z_in_i(z_in),
    .mar_in_i(mar_in), .mdr_out_i(mdr_out), .mdr_in_i(mdr_in), .mdr_mem_in_i(mdr_mem_in),
    .mdr_mem_out_i(mdr_mem_out), .sel_const_i(sel_const), .alu_op_i(alu_op), .carry_i(carry),
    .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .mem_done_i(mem_done), .mem_rdata_i(mem_rdata),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_wdata_en_o(mem_wdata_en),
    .mem_rd_o(mem_rd_v), .mem_wr_o(mem_wr_v), .ir_o(ir_v), .bus_o(bus_v));

  int n_run = 0;
  int n_fail = 0;

  logic [DW-1:0] m_gpr [NREG];
  logic [DW-1:0] m_pc, m_ir, m_tmp, m_y, m_z, m_mar, m_mdr;

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    gpr_out = '0; gpr_in = '0;
    {pc_out, pc_in, ir_out, ir_in, tmp_out, tmp_in, y_in, z_out, z_in, mar_in} = '0;
    {mdr_out, mdr_in, mdr_mem_in, mdr_mem_out, sel_const, carry, mem_rd, mem_wr, mem_done} = '0;
    alu_op = 3'd0; mem_rdata = '0;
  endtask

  function automatic logic [DW-1:0] model_bus();
    logic [DW-1:0] v = '0;
    for (int i = 0; i < NREG; i++) if (gpr_out[i]) v |= m_gpr[i];
    if (pc_out)  v |= m_pc;
    if (ir_out)  v |= m_ir;
    if (tmp_out) v |= m_tmp;
    if (z_out)   v |= m_z;
    if (mdr_out) v |= m_mdr;
    return v;
  endfunction

  function automatic logic [DW-1:0] model_alu(logic [2:0] op, logic [DW-1:0] a, logic [DW-1:0] b, logic c);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b - 32'(!c);
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return b;
      3'd6: return a;
      default: return '0;
    endcase
  endfunction

  // compare all outputs against the model, clock once, update model
  task automatic step(string tag);
    logic [DW-1:0] eb, res;
    #1;
    eb = model_bus();
    check({tag, " R2 R10 bus"}, bus_v, eb);
    check("R7 mem_addr", mem_addr, m_mar);
    check("R7 rd/wr", {30'd0, mem_rd_v, mem_wr_v}, {30'd0, mem_rd, mem_wr});
    check("R9 wdata", mem_wdata, m_mdr);
    check("R9 wdata_en", {31'd0, mem_wdata_en}, {31'd0, mdr_mem_out});
    check("R3 ir_o", ir_v, m_ir);
    res = model_alu(alu_op, sel_const ? 32'd4 : m_y, eb, carry);
    @(posedge clk);
    for (int i = 0; i < NREG; i++) if (gpr_in[i]) m_gpr[i] = eb;
    if (pc_in)  m_pc  = eb;
    if (ir_in)  m_ir  = eb;
    if (tmp_in) m_tmp = eb;
    if (y_in)   m_y   = eb;
    if (z_in)   m_z   = res;
    if (mar_in) m_mar = eb;
    if (mdr_mem_in && mem_done) m_mdr = mem_rdata;
    else if (mdr_in)            m_mdr = eb;
    @(negedge clk);
    idle();
  endtask

  task automatic load_gpr(int i, logic [DW-1:0] v);
    mdr_mem_in = 1; mem_done = 1; mem_rdata = v; mem_rd = 1; step("R8 load");
    mdr_out = 1; gpr_in[i] = 1; step("R3 move");
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    for (int i = 0; i < NREG; i++) m_gpr[i] = '0;
    {m_pc, m_ir, m_tmp, m_y, m_z, m_mar, m_mdr} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: every register reads zero after reset
    for (int i = 0; i < NREG; i++) begin gpr_out[i] = 1; step("R1 gpr"); end
    pc_out = 1;  step("R1 pc");
    ir_out = 1;  step("R1 ir");
    tmp_out = 1; step("R1 tmp");
    z_out = 1;   step("R1 z");
    mdr_out = 1; step("R1 mdr");
    sel_const = 0; alu_op = 3'd6; z_in = 1; step("R1 y");
    z_out = 1; step("R1 y via z");
    step("R2 idle bus");

    for (int i = 0; i < NREG; i++) load_gpr(i, 32'h1000_0011 * (i + 1));
    for (int i = 0; i < NREG; i++) begin gpr_out[i] = 1; step("R3 readback"); end

    // R8: memory load without completion is ignored
    mdr_mem_in = 1; mem_done = 0; mem_rdata = 32'hDEAD_BEEF; step("R8 no done");
    mdr_out = 1; step("R8 mdr held");
    // R8 priority: memory beats bus when done, bus wins without done
    gpr_out[5] = 1; mdr_in = 1; mdr_mem_in = 1; mem_done = 1; mem_rdata = 32'hCAFE_0001; step("R8 both");
    mdr_out = 1; step("R8 mem wins");
    gpr_out[6] = 1; mdr_in = 1; mdr_mem_in = 1; mem_done = 0; mem_rdata = 32'h5555_AAAA; step("R8 bus only");
    mdr_out = 1; step("R8 bus wins");

    // R4: three-step R3 = R1 + R2
    gpr_out[1] = 1; y_in = 1; step("R4 y");
    gpr_out[2] = 1; alu_op = 3'd0; z_in = 1; step("R4 add");
    z_out = 1; gpr_in[3] = 1; step("R4 z to r3");
    gpr_out[3] = 1; step("R4 r3 sum");

    // R4/R6: every function code with both carry values
    for (int op = 0; op < 8; op++)
      for (int c = 0; c < 2; c++) begin
        gpr_out[7] = 1; alu_op = 3'(op); carry = c[0]; z_in = 1; step("R4 R6 op");
        z_out = 1; step("R4 R6 result");
      end

    // R5/R7: PC increment with address to MAR and read strobe
    load_gpr(0, 32'h0000_0100);
    gpr_out[0] = 1; pc_in = 1; step("R3 pc load");
    pc_out = 1; mar_in = 1; mem_rd = 1; sel_const = 1; alu_op = 3'd0; z_in = 1; step("R5 R7 fetch");
    z_out = 1; pc_in = 1; mdr_mem_in = 1; mem_done = 1; mem_rdata = 32'h0BAD_F00D; step("R5 pc+4");
    mdr_out = 1; ir_in = 1; step("R3 ir load");
    pc_out = 1; step("R5 pc value");
    ir_out = 1; tmp_in = 1; step("R3 tmp load");
    tmp_out = 1; step("R3 tmp value");

    // R9: write path
    gpr_out[4] = 1; mdr_in = 1; step("R9 mdr from bus");
    mdr_mem_out = 1; mem_wr = 1; step("R9 write");

    // R11: drive and load in one cycle
    z_out = 1; z_in = 1; sel_const = 1; alu_op = 3'd6; step("R11 z same cycle");
    z_out = 1; step("R11 z new");
    mdr_out = 1; mdr_mem_in = 1; mem_done = 1; mem_rdata = 32'h1234_5678; step("R11 mdr same cycle");
    mdr_out = 1; step("R11 mdr new");
    gpr_out[2] = 1; gpr_in[2] = 1; step("R11 self copy");
    gpr_out[2] = 1; step("R11 self value");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule